// File: doc/BRIEF.md
# Spiral Kernel Source Address Generator

This block produces source-image pixel addresses for one axis (row or column) of a two-dimensional image resampler. For every output pixel it visits a square neighbourhood of (k+1)x(k+1) taps by walking outward in a square spiral, or, for separable two-pass filtering, a straight line of k+1 taps along one axis. Two instances, one per axis, produce a full (x,y) source address stream.

Position is held in a signed fixed-point accumulator. Its integer part, clamped to the image range, is the source address; its top fraction bits and the tap index form a coefficient RAM address for an external interpolator. When a walk finishes, a per-walk increment is added to the address of the last tap visited; when a line of walks finishes, a per-line increment is added to the remembered line-start address instead; when the last line finishes, the walk restarts from the start position. Configuration is captured when a new transform is started and held until the next start.

Top module: `spiral_src_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle: `active`, `tap_first`, `walk_last`, `line_last`, `frame_last` are 0, and `src_addr` and `coef_addr` are 0.
- R2: A clock edge with `init` high captures all configuration inputs, places the accumulator at `start_pos` and the tap index at 0, and sets `active`; the outputs then show tap 0 until the first edge with `init` low.
- R3: With `mode` 2'b00 (clockwise spiral), taps visit the offsets (0,0),(+1,0),(+1,+1),(0,+1),(-1,+1),(-1,0),(-1,-1),(0,-1),(+1,-1) and onward in legs of length 1,1,2,2,3,3,... turning +x, +y, -x, -y; `axis_col`=0 follows the x offset, `axis_col`=1 the y offset; a walk has (k+1)^2 taps.
- R4: With `mode` 2'b10 (counter-clockwise spiral), x offsets equal the clockwise ones and y offsets are negated.
- R5: With `mode` 2'b01 a walk has k+1 taps and the row axis steps +1 per tap while the column axis holds; with `mode` 2'b11 the column axis steps and the row axis holds.
- R6: Each spiral or line step moves the address by `fov` pixels (0 to 7); with `fov` 0 the address stays on the first tap for the whole walk.
- R7: The first tap of the next walk within a line equals the last-tap accumulator value plus `inc_walk`.
- R8: After `walks_per_line` walks, the next walk starts at the previous line start plus `inc_line`, and that becomes the new line start.
- R9: After `lines_per_frame` lines, the next walk starts again at the captured `start_pos`.
- R10: `coef_addr` bits [7:4] are accumulator fraction bits [11:8]; bits [3:0] are the low 4 bits of the tap index.
- R11: `src_addr` is accumulator bits [23:12] when the integer part is 0 to 4095, 0 when it is negative, and 4095 when it exceeds 4095.
- R12: Changes on the configuration inputs while `init` is low have no effect on the address stream.
- R13: `walk_last` is high on the last tap of a walk, `line_last` on the last tap of the last walk of a line, `frame_last` on the last tap of the frame, and `tap_first` on tap 0 while active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Start a new transform and capture configuration |
| mode | input | 2 | 00 cw spiral, 10 ccw spiral, 01 row line, 11 column line |
| axis_col | input | 1 | 0 row (x) axis, 1 column (y) axis |
| kern | input | 4 | Kernel size k, walk side k+1 |
| fov | input | 3 | Pixel distance per step |
| start_pos | input | 28 | Signed start position, 12 fraction bits |
| inc_walk | input | 28 | Signed per-walk increment, 12 fraction bits |
| inc_line | input | 28 | Signed per-line increment, 12 fraction bits |
| walks_per_line | input | 12 | Walks in one line |
| lines_per_frame | input | 12 | Lines in one frame |
| active | output | 1 | Transform running |
| src_addr | output | 12 | Clamped integer source address |
| coef_addr | output | 8 | Coefficient RAM address |
| tap_first | output | 1 | First tap of a walk |
| walk_last | output | 1 | Last tap of a walk |
| line_last | output | 1 | Last tap of a line |
| frame_last | output | 1 | Last tap of a frame |

## Verification
A wrong segment counter or turn direction shows on `src_addr` within the same walk, at the first tap after the bad turn, and on `coef_addr` low nibble whenever the tap index is off. A wrong increment selection or lost line-start value appears at the first tap after a walk, line or frame boundary, so every case runs a full frame and a few taps past its restart. Fraction errors surface on the upper coefficient nibble before they ever reach the integer address, which is why both outputs are compared on every cycle.

// File: rtl/spiral_addr_pkg.sv
// Shared types for the spiral source address generator.
// Assumes walk modes are encoded as two bits; bit 0 clear means spiral.
package spiral_addr_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_POS  = 2'b01,
        STEP_NEG  = 2'b10
    } step_e;

    localparam logic [1:0] WALK_CW    = 2'b00;
    localparam logic [1:0] WALK_HLINE = 2'b01;
    localparam logic [1:0] WALK_CCW   = 2'b10;
    localparam logic [1:0] WALK_VLINE = 2'b11;

    function automatic logic is_spiral(input logic [1:0] m);
        return ~m[0];
    endfunction

endpackage

// File: rtl/spiral_stepper.sv
// Tap sequencer: tracks the tap index inside one walk and, for spiral modes,
// the current leg (direction, length, position). Emits the step this axis
// takes to move from the current tap to the next one.
// Assumes mode, axis and kernel are held stable between restarts.
module spiral_stepper
    import spiral_addr_pkg::*;
#(
    parameter int KW    = 4,
    parameter int TAP_W = 2 * KW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [1:0]       mode,
    input  logic             axis_col,
    input  logic [KW-1:0]    kern,
    output logic [TAP_W-1:0] tap_idx,
    output logic             last_tap,
    output step_e            step
);
    localparam int SEG_W = KW + 1;

    logic [TAP_W-1:0]   tap_q;
    logic [1:0]         dir_q;
    logic [SEG_W-1:0]   len_q;
    logic [SEG_W-1:0]   pos_q;
    logic               half_q;
    logic [SEG_W-1:0]   kp1;
    logic [2*SEG_W-1:0] sq;
    logic [2*SEG_W-1:0] sq_m1;
    logic [TAP_W-1:0]   last_idx;

    // Index of the final tap: (k+1)^2-1 for spirals, k for line walks.
    always_comb begin
        kp1      = {1'b0, kern} + SEG_W'(1);
        sq       = {{SEG_W{1'b0}}, kp1} * {{SEG_W{1'b0}}, kp1};
        sq_m1    = sq - {{(2*SEG_W-1){1'b0}}, 1'b1};
        last_idx = is_spiral(mode) ? sq_m1[TAP_W-1:0] : TAP_W'(kern);
    end

    assign last_tap = (tap_q == last_idx);
    assign tap_idx  = tap_q;

    // Walk state: restart at tap 0 on init or after the last tap, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || (advance && last_tap)) begin
            tap_q  <= '0;
            dir_q  <= 2'd0;
            len_q  <= SEG_W'(1);
            pos_q  <= '0;
            half_q <= 1'b0;
        end else if (advance) begin
            tap_q <= tap_q + TAP_W'(1);
            if (pos_q + SEG_W'(1) == len_q) begin
                pos_q  <= '0;
                dir_q  <= dir_q + 2'd1;
                half_q <= ~half_q;
                if (half_q) len_q <= len_q + SEG_W'(1);
            end else begin
                pos_q <= pos_q + SEG_W'(1);
            end
        end
    end

    // Project the current leg direction (or line mode) onto this axis.
    always_comb begin
        step = STEP_NONE;
        if (is_spiral(mode)) begin
            if (!axis_col) begin
                if (dir_q == 2'd0)      step = STEP_POS;
                else if (dir_q == 2'd2) step = STEP_NEG;
            end else begin
                if (dir_q == 2'd1)      step = (mode == WALK_CCW) ? STEP_NEG : STEP_POS;
                else if (dir_q == 2'd3) step = (mode == WALK_CCW) ? STEP_POS : STEP_NEG;
            end
        end else if ((mode == WALK_HLINE && !axis_col) ||
                     (mode == WALK_VLINE &&  axis_col)) begin
            step = STEP_POS;
        end
    end

    // R3
    tap_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> tap_q <= last_idx);

    // R3
    leg_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < len_q);

endmodule

// File: rtl/accum_unit.sv
// Fixed-point position accumulator with a remembered line start.
// Steps by fov pixels inside a walk, adds the walk increment to the last-tap
// value at walk end, the line increment to the line start at line end, and
// returns to the home position at frame end.
// Assumes fov and increments are held stable between restarts.
module accum_unit
    import spiral_addr_pkg::*;
#(
    parameter int ACC_W  = 28,
    parameter int FRAC_W = 12,
    parameter int FOV_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    advance,
    input  logic                    last_tap,
    input  logic                    line_end,
    input  logic                    frame_end,
    input  step_e                   step,
    input  logic [FOV_W-1:0]        fov,
    input  logic signed [ACC_W-1:0] load_pos,
    input  logic signed [ACC_W-1:0] home_pos,
    input  logic signed [ACC_W-1:0] inc_walk,
    input  logic signed [ACC_W-1:0] inc_line,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] line_q;
    logic signed [ACC_W-1:0] stride;
    logic signed [ACC_W-1:0] next_line;

    assign stride    = signed'({{(ACC_W-FOV_W){1'b0}}, fov}) <<< FRAC_W;
    assign next_line = line_q + inc_line;
    assign acc       = acc_q;

    // Position and line-start update for each tap, walk, line and frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            line_q <= '0;
        end else if (restart) begin
            acc_q  <= load_pos;
            line_q <= load_pos;
        end else if (advance) begin
            if (!last_tap) begin
                if (step == STEP_POS)      acc_q <= acc_q + stride;
                else if (step == STEP_NEG) acc_q <= acc_q - stride;
            end else if (frame_end) begin
                acc_q  <= home_pos;
                line_q <= home_pos;
            end else if (line_end) begin
                acc_q  <= next_line;
                line_q <= next_line;
            end else begin
                acc_q <= acc_q + inc_walk;
            end
        end
    end

    // R6
    hold_on_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && !last_tap && step == STEP_NONE) |=> $stable(acc_q));

    // R2
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> acc_q == $past(load_pos));

endmodule

// File: rtl/addr_format.sv
// Output formatting: clamps the accumulator integer part into the address
// range and builds the coefficient address from fraction bits and tap index.
// Assumes the integer part is wider than the address.
module addr_format #(
    parameter int ACC_W   = 28,
    parameter int FRAC_W  = 12,
    parameter int ADDR_W  = 12,
    parameter int CA_HI_W = 4,
    parameter int CA_LO_W = 4,
    parameter int TAP_W   = 8
) (
    input  logic signed [ACC_W-1:0]   acc,
    input  logic [TAP_W-1:0]          tap_idx,
    output logic [ADDR_W-1:0]         src_addr,
    output logic [CA_HI_W+CA_LO_W-1:0] coef_addr
);
    localparam int INT_W = ACC_W - FRAC_W;

    logic [INT_W-1:0] int_part;
    logic             too_high;

    assign int_part = acc[ACC_W-1:FRAC_W];

    generate
        if (INT_W - 1 > ADDR_W) begin : g_ovf
            assign too_high = |int_part[INT_W-2:ADDR_W];
        end else begin : g_noovf
            assign too_high = 1'b0;
        end
    endgenerate

    // Clamp negative to zero and large values to the top address.
    always_comb begin
        if (int_part[INT_W-1])  src_addr = '0;
        else if (too_high)      src_addr = '1;
        else                    src_addr = int_part[ADDR_W-1:0];
    end

    assign coef_addr = {acc[FRAC_W-1 -: CA_HI_W], tap_idx[CA_LO_W-1:0]};

endmodule

// File: rtl/spiral_src_addr_gen.sv
// Top: one-axis source address generator for a kernel-walking resampler.
// Captures configuration on init, counts walks per line and lines per frame,
// and ties the stepper, accumulator and output formatter together.
// Assumes walks_per_line and lines_per_frame are at least 1 (0 acts as 1).
module spiral_src_addr_gen
    import spiral_addr_pkg::*;
#(
    parameter int ACC_W   = 28,
    parameter int FRAC_W  = 12,
    parameter int ADDR_W  = 12,
    parameter int KW      = 4,
    parameter int FOV_W   = 3,
    parameter int CNT_W   = 12,
    parameter int CA_HI_W = 4,
    parameter int CA_LO_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       init,
    input  logic [1:0]                 mode,
    input  logic                       axis_col,
    input  logic [KW-1:0]              kern,
    input  logic [FOV_W-1:0]           fov,
    input  logic [ACC_W-1:0]           start_pos,
    input  logic [ACC_W-1:0]           inc_walk,
    input  logic [ACC_W-1:0]           inc_line,
    input  logic [CNT_W-1:0]           walks_per_line,
    input  logic [CNT_W-1:0]           lines_per_frame,
    output logic                       active,
    output logic [ADDR_W-1:0]          src_addr,
    output logic [CA_HI_W+CA_LO_W-1:0] coef_addr,
    output logic                       tap_first,
    output logic                       walk_last,
    output logic                       line_last,
    output logic                       frame_last
);
    localparam int TAP_W = 2 * KW;

    logic [1:0]              cfg_mode;
    logic                    cfg_axis;
    logic [KW-1:0]           cfg_kern;
    logic [FOV_W-1:0]        cfg_fov;
    logic signed [ACC_W-1:0] cfg_start;
    logic signed [ACC_W-1:0] cfg_inc_walk;
    logic signed [ACC_W-1:0] cfg_inc_line;
    logic [CNT_W-1:0]        cfg_walks;
    logic [CNT_W-1:0]        cfg_lines;
    logic                    run_q;
    logic [CNT_W-1:0]        walk_cnt_q;
    logic [CNT_W-1:0]        line_cnt_q;
    logic                    advance;
    logic [TAP_W-1:0]        tap_idx;
    logic                    last_tap;
    step_e                   step;
    logic signed [ACC_W-1:0] acc;
    logic                    line_end;
    logic                    frame_end;

    // Configuration capture at transform start; held for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode     <= WALK_CW;
            cfg_axis     <= 1'b0;
            cfg_kern     <= '0;
            cfg_fov      <= '0;
            cfg_start    <= '0;
            cfg_inc_walk <= '0;
            cfg_inc_line <= '0;
            cfg_walks    <= '0;
            cfg_lines    <= '0;
        end else if (init) begin
            cfg_mode     <= mode;
            cfg_axis     <= axis_col;
            cfg_kern     <= kern;
            cfg_fov      <= fov;
            cfg_start    <= signed'(start_pos);
            cfg_inc_walk <= signed'(inc_walk);
            cfg_inc_line <= signed'(inc_line);
            cfg_walks    <= walks_per_line;
            cfg_lines    <= lines_per_frame;
        end
    end

    // Running flag: set by init, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 1'b0;
        else if (init) run_q <= 1'b1;
    end

    assign advance   = run_q && !init;
    assign line_end  = ({1'b0, walk_cnt_q} + (CNT_W+1)'(1)) >= {1'b0, cfg_walks};
    assign frame_end = line_end &&
                       (({1'b0, line_cnt_q} + (CNT_W+1)'(1)) >= {1'b0, cfg_lines});

    // Walk and line counters advance on the last tap of each walk.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            walk_cnt_q <= '0;
            line_cnt_q <= '0;
        end else if (advance && last_tap) begin
            if (line_end) begin
                walk_cnt_q <= '0;
                line_cnt_q <= frame_end ? '0 : line_cnt_q + CNT_W'(1);
            end else begin
                walk_cnt_q <= walk_cnt_q + CNT_W'(1);
            end
        end
    end

    spiral_stepper #(.KW(KW), .TAP_W(TAP_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (init),
        .advance  (advance),
        .mode     (cfg_mode),
        .axis_col (cfg_axis),
        .kern     (cfg_kern),
        .tap_idx  (tap_idx),
        .last_tap (last_tap),
        .step     (step)
    );

    accum_unit #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .FOV_W(FOV_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (init),
        .advance   (advance),
        .last_tap  (last_tap),
        .line_end  (line_end),
        .frame_end (frame_end),
        .step      (step),
        .fov       (cfg_fov),
        .load_pos  (signed'(start_pos)),
        .home_pos  (cfg_start),
        .inc_walk  (cfg_inc_walk),
        .inc_line  (cfg_inc_line),
        .acc       (acc)
    );

    addr_format #(
        .ACC_W(ACC_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W),
        .CA_HI_W(CA_HI_W), .CA_LO_W(CA_LO_W), .TAP_W(TAP_W)
    ) u_fmt (
        .acc       (acc),
        .tap_idx   (tap_idx),
        .src_addr  (src_addr),
        .coef_addr (coef_addr)
    );

    assign active     = run_q;
    assign tap_first  = run_q && (tap_idx == '0);
    assign walk_last  = run_q && last_tap;
    assign line_last  = walk_last && line_end;
    assign frame_last = walk_last && frame_end;

    // R13
    line_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_last |-> walk_last);

    // R13
    frame_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |-> line_last);

    // R7
    walk_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && walk_last) |=> tap_first);

    // R2
    init_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (active && tap_first));

endmodule

// File: tb/sim_spiral_src_addr_gen.sv
module sim_spiral_src_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        axis_col = 1'b0;
    logic [3:0]  kern = '0;
    logic [2:0]  fov = '0;
    logic [27:0] start_pos = '0, inc_walk = '0, inc_line = '0;
    logic [11:0] walks_per_line = '0, lines_per_frame = '0;
    logic        active, tap_first, walk_last, line_last, frame_last;
    logic [11:0] src_addr;
    logic [7:0]  coef_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic [1:0] m_mode;
    logic       m_axis;
    int         m_k, m_fov, m_nw, m_nl, m_t, m_walk, m_line;
    longint     m_start, m_du, m_dv, m_base, m_lb;
    string      m_tag;

    always #4 clk = ~clk;

    spiral_src_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .init(init), .mode(mode), .axis_col(axis_col),
        .kern(kern), .fov(fov), .start_pos(start_pos), .inc_walk(inc_walk),
        .inc_line(inc_line), .walks_per_line(walks_per_line),
        .lines_per_frame(lines_per_frame), .active(active), .src_addr(src_addr),
        .coef_addr(coef_addr), .tap_first(tap_first), .walk_last(walk_last),
        .line_last(line_last), .frame_last(frame_last)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int last_idx(input logic [1:0] md, input int k);
        return md[0] ? k : (k + 1) * (k + 1) - 1;
    endfunction

    // Offset of tap t from the walk's first tap along this axis.
    function automatic longint off(input int t, input logic [1:0] md, input logic ax);
        int x = 0, y = 0, rem = t, len = 1, d = 0;
        if (md[0]) begin
            if ((md == 2'b01 && !ax) || (md == 2'b11 && ax)) return t;
            return 0;
        end
        while (rem > 0) begin
            for (int leg = 0; leg < 2 && rem > 0; leg++) begin
                for (int s = 0; s < len && rem > 0; s++) begin
                    case (d)
                        0: x++;
                        1: y++;
                        2: x--;
                        default: y--;
                    endcase
                    rem--;
                end
                d = (d + 1) % 4;
            end
            len++;
        end
        if (md == 2'b10) y = -y;
        return ax ? y : x;
    endfunction

    function automatic longint cur_acc();
        return m_base + off(m_t, m_mode, m_axis) * m_fov * 4096;
    endfunction

    function automatic longint sat(input longint a);
        longint ip = a >>> 12;
        if (ip < 0) return 0;
        if (ip > 4095) return 4095;
        return ip;
    endfunction

    task automatic check_now();
        longint a = cur_acc();
        bit wl = (m_t == last_idx(m_mode, m_k));
        bit ll = wl && (m_walk + 1 >= m_nw);
        bit fl = ll && (m_line + 1 >= m_nl);
        chk(m_tag, src_addr, sat(a));
        chk("R10", coef_addr, ((a >> 8) & 15) * 16 + (m_t & 15));
        chk("R13", tap_first, (m_t == 0));
        chk("R13", walk_last, wl);
        chk("R13", line_last, ll);
        chk("R13", frame_last, fl);
    endtask

    task automatic step_model(input string base_tag);
        if (m_t < last_idx(m_mode, m_k)) begin
            m_t++;
            m_tag = base_tag;
        end else begin
            longint la = cur_acc();
            m_t = 0;
            if (m_walk + 1 >= m_nw) begin
                m_walk = 0;
                if (m_line + 1 >= m_nl) begin
                    m_line = 0; m_base = m_start; m_lb = m_start; m_tag = "R9";
                end else begin
                    m_line++; m_lb = m_lb + m_dv; m_base = m_lb; m_tag = "R8";
                end
            end else begin
                m_walk++; m_base = la + m_du; m_tag = "R7";
            end
        end
    endtask

    task automatic run_case(input string tag, input logic [1:0] md, input int k,
                            input int fv, input logic ax, input longint st,
                            input longint du, input longint dv, input int nw,
                            input int nl, input bit scramble);
        int n;
        @(negedge clk);
        mode = md; kern = 4'(k); fov = 3'(fv); axis_col = ax;
        start_pos = 28'(st); inc_walk = 28'(du); inc_line = 28'(dv);
        walks_per_line = 12'(nw); lines_per_frame = 12'(nl);
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        m_mode = md; m_k = k; m_fov = fv; m_axis = ax; m_start = st;
        m_du = du; m_dv = dv; m_nw = nw; m_nl = nl;
        m_t = 0; m_walk = 0; m_line = 0; m_base = st; m_lb = st; m_tag = "R2";
        chk("R2", active, 1);
        n = (last_idx(md, k) + 1) * nw * nl + 4;
        for (int i = 0; i < n; i++) begin
            check_now();
            if (scramble) begin
                mode = 2'($urandom); kern = 4'($urandom); fov = 3'($urandom);
                axis_col = 1'($urandom); start_pos = 28'($urandom);
                inc_walk = 28'($urandom); inc_line = 28'($urandom);
                walks_per_line = 12'($urandom); lines_per_frame = 12'($urandom);
            end
            step_model(tag);
            @(negedge clk);
        end
    endtask

    task automatic literal_walk(input string tag, input logic [1:0] md,
                                input logic ax, input int exp_seq [9]);
        @(negedge clk);
        mode = md; kern = 4'd2; fov = 3'd1; axis_col = ax;
        start_pos = 28'(6 * 4096); inc_walk = '0; inc_line = '0;
        walks_per_line = 12'd1; lines_per_frame = 12'd1; init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        for (int i = 0; i < 9; i++) begin
            chk(tag, src_addr, exp_seq[i]);
            @(negedge clk);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5eed2301);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", active, 0);
        chk("R1", src_addr, 0);
        chk("R1", coef_addr, 0);
        chk("R1", tap_first | walk_last | line_last | frame_last, 0);
        rst_n = 1'b1;

        // R3 / R4 literal spiral orders from (6,6)
        literal_walk("R3", 2'b00, 1'b0, '{6, 7, 7, 6, 5, 5, 5, 6, 7});
        literal_walk("R3", 2'b00, 1'b1, '{6, 6, 7, 7, 7, 6, 5, 5, 5});
        literal_walk("R4", 2'b10, 1'b1, '{6, 6, 5, 5, 5, 6, 7, 7, 7});

        // 3x3 filter on both axes, two lines of three walks (R7 R8 R9)
        run_case("R3", 2'b00, 2, 1, 1'b0, 6 * 4096, 0, 0, 3, 2, 1'b0);
        run_case("R3", 2'b00, 2, 1, 1'b1, 6 * 4096, 4096, 4096, 3, 2, 1'b0);
        run_case("R4", 2'b10, 2, 1, 1'b1, 6 * 4096, 4096, 4096, 3, 2, 1'b0);
        // 2x2 rotation with fractional increments (R10)
        run_case("R10", 2'b00, 1, 1, 1'b0, 0, 3547, -2048, 3, 3, 1'b0);
        run_case("R10", 2'b00, 1, 1, 1'b1, 0, -2048, 3547, 3, 3, 1'b0);
        // line walks (R5)
        run_case("R5", 2'b01, 2, 1, 1'b0, 0, -4096, 0, 3, 2, 1'b0);
        run_case("R5", 2'b01, 2, 1, 1'b1, 0, 0, 4096, 3, 2, 1'b0);
        run_case("R5", 2'b11, 2, 1, 1'b1, 0, -8192, 4096, 3, 2, 1'b0);
        run_case("R5", 2'b11, 2, 1, 1'b0, 0, 4096, 0, 3, 2, 1'b0);
        // spacing (R6)
        run_case("R6", 2'b00, 3, 0, 1'b0, 20 * 4096, 4096, 0, 2, 1, 1'b0);
        run_case("R6", 2'b00, 3, 3, 1'b1, 40 * 4096, 512, 8192, 2, 2, 1'b0);
        // clamping (R11)
        run_case("R11", 2'b00, 2, 1, 1'b0, -3 * 4096, 4096, 0, 3, 1, 1'b0);
        run_case("R11", 2'b00, 2, 2, 1'b0, 4094 * 4096, 4096, 0, 2, 1, 1'b0);
        // configuration inputs toggled mid-run (R12)
        run_case("R12", 2'b10, 3, 2, 1'b0, 100 * 4096, 777, -1234, 2, 2, 1'b1);

        // constrained random
        for (int c = 0; c < 30; c++) begin
            run_case("R3", 2'($urandom), int'($urandom_range(0, 3)),
                     int'($urandom_range(0, 3)), 1'($urandom),
                     longint'($urandom_range(0, 300000)) - 20000,
                     longint'($urandom_range(0, 65535)) - 32768,
                     longint'($urandom_range(0, 65535)) - 32768,
                     int'($urandom_range(1, 3)), int'($urandom_range(1, 2)), 1'b0);
        end

        // reset while running returns to idle (R1)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", active, 0);
        chk("R1", src_addr, 0);
        finish_up();
    end
endmodule